// File: doc/BRIEF.md
# Folded Constant-Geometry 16-Point FFT Engine

This block computes a 16-point radix-2 complex FFT on signed fixed-point samples. It uses the constant-geometry arrangement: each of the four stages applies the same lane wiring. Butterfly `k` takes its operands from lanes `k` and `k+8` and writes its two results to lanes `2k` and `2k+1`. Because that pattern never changes, a single stage of butterfly hardware is reused for all four passes, and each stage's results are fed back into it for the next pass.

The parameter `P` sets how many physical butterflies are built. It must divide 8. A stage is then split into `8/P` sub-cycles, so one transform takes `4*8/P` cycles. With `P=8` that is 4 cycles, with `P=4` it is 8, with `P=2` it is 16, and with `P=1` it is 32. Twiddle factors are Q2.14 constants held in an internal table of eight entries.

A full vector enters through a valid/ready handshake and the result leaves through another. On the input side the engine raises `in_ready` only when it is idle, so a producer holding `in_valid` high waits while a transform runs and while its result has not yet been taken. On the output side `out_valid` and the result stay fixed until the consumer raises `out_ready`. No new vector is accepted before that handshake completes.

Top module: `cg_fft_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: After a vector is accepted (`in_valid` and `in_ready` both high at a clock edge), `in_ready` stays 0 until the result has been taken. Any `in_valid` or input data presented during that time is ignored and does not change the result.
- R3: `out_valid` rises exactly `32/P` clock edges after the edge that accepted the vector.
- R4: Input sample `n` sits in bits `[n*W +: W]` of `in_re` and `in_im`, in natural order. Output lane `r` (bits `[r*W +: W]`) holds DFT bin `bitrev4(r)` divided by 16. Each component is within 6 LSB of the exact value.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_re` and `out_im` do not change.
- R6: One cycle after a clock edge with `out_valid` and `out_ready` both high, `out_valid` is 0 and `in_ready` is 1.
- R7: An impulse of real amplitude `A` in sample 0, with every other sample zero, gives exactly `A>>>4` in the real part of every lane and exactly 0 in every imaginary part.
- R8: Each butterfly forms the twiddle product `t = w*b` truncated by 14 fraction bits. Its outputs are `(a+t)>>>1` and `(a-t)>>>1`, so the sum of its two outputs equals `a` or `a-1` in each component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is present |
| in_ready | output | 1 | Engine is idle and will take a vector |
| in_re | input | 16*W | Real parts, sample n at bits [n*W +: W] |
| in_im | input | 16*W | Imaginary parts, same layout |
| out_valid | output | 1 | Result vector is present |
| out_ready | input | 1 | Consumer takes the result |
| out_re | output | 16*W | Real parts, lane r holds bin bitrev4(r) |
| out_im | output | 16*W | Imaginary parts, same layout |

## Verification
Assertions check on every cycle that the output stays put under back-pressure, that the engine goes busy after accepting a vector and becomes idle again after the result is taken, and that the pass counter gives the exact fold latency. They also check the half-sum relation between each butterfly's two outputs. Only the bench's scenarios can show that the shuffle and twiddle schedule really yield a DFT in bit-reversed lane order, that the impulse result is exact, and that data driven while the engine is busy leaves the result unchanged. The bench covers random vectors, an impulse, a constant input and a single tone.

// File: rtl/cg_fft_pkg.sv
package cg_fft_pkg;
  localparam int NPT     = 16;
  localparam int HALF    = NPT / 2;
  localparam int NSTG    = 4;
  localparam int TW_W    = 16;
  localparam int TW_FRAC = 14;

  typedef enum logic [1:0] {EN_IDLE, EN_RUN, EN_DONE} eng_state_e;

  // Twiddle exponent (in units of 2*pi/16) for butterfly k in pass s:
  // the low s bits of k, bit-reversed, shifted up by (3-s).
  function automatic logic [2:0] tw_index(input logic [1:0] s, input logic [2:0] k);
    logic [2:0] r;
    r = '0;
    for (int b = 0; b < 3; b++) begin
      if (b < int'(s)) r[2-b] = k[b];
    end
    return r;
  endfunction
endpackage

// File: rtl/cg_twiddle_rom.sv
module cg_twiddle_rom
  import cg_fft_pkg::*;
(
  input  logic [2:0]             idx,
  output logic signed [TW_W-1:0] w_re,
  output logic signed [TW_W-1:0] w_im
);
  // exp(-j*2*pi*idx/16) in Q2.14
  always_comb begin
    case (idx)
      3'd0: begin w_re =  16'sd16384; w_im =  16'sd0;      end
      3'd1: begin w_re =  16'sd15137; w_im = -16'sd6270;   end
      3'd2: begin w_re =  16'sd11585; w_im = -16'sd11585;  end
      3'd3: begin w_re =  16'sd6270;  w_im = -16'sd15137;  end
      3'd4: begin w_re =  16'sd0;     w_im = -16'sd16384;  end
      3'd5: begin w_re = -16'sd6270;  w_im = -16'sd15137;  end
      3'd6: begin w_re = -16'sd11585; w_im = -16'sd11585;  end
      default: begin w_re = -16'sd15137; w_im = -16'sd6270; end
    endcase
  end
endmodule

// File: rtl/cg_butterfly.sv
module cg_butterfly
  import cg_fft_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0]    a_re,
  input  logic signed [W-1:0]    a_im,
  input  logic signed [W-1:0]    b_re,
  input  logic signed [W-1:0]    b_im,
  input  logic signed [TW_W-1:0] w_re,
  input  logic signed [TW_W-1:0] w_im,
  output logic signed [W-1:0]    x_re,
  output logic signed [W-1:0]    x_im,
  output logic signed [W-1:0]    y_re,
  output logic signed [W-1:0]    y_im
);
  localparam int PW = W + TW_W + 1;
  localparam int EW = W + 2;

  logic signed [PW-1:0] p_re, p_im;
  logic signed [EW-1:0] t_re, t_im, ea_re, ea_im;
  logic signed [EW-1:0] sx_re, sx_im, sy_re, sy_im;

  always_comb begin
    p_re  = b_re * w_re - b_im * w_im;
    p_im  = b_re * w_im + b_im * w_re;
    t_re  = p_re[TW_FRAC +: EW];
    t_im  = p_im[TW_FRAC +: EW];
    ea_re = EW'(a_re);
    ea_im = EW'(a_im);
    sx_re = ea_re + t_re;
    sx_im = ea_im + t_im;
    sy_re = ea_re - t_re;
    sy_im = ea_im - t_im;
    x_re  = sx_re[W:1];
    x_im  = sx_im[W:1];
    y_re  = sy_re[W:1];
    y_im  = sy_im[W:1];
  end

  // R8: the two halved outputs sum to a or a-1 per component
  logic signed [W:0] ps_re, ps_im, aw_re, aw_im;
  always_comb begin
    ps_re = (W+1)'(x_re) + (W+1)'(y_re);
    ps_im = (W+1)'(x_im) + (W+1)'(y_im);
    aw_re = (W+1)'(a_re);
    aw_im = (W+1)'(a_im);
    p_pair_sum_r8: assert ((ps_re == aw_re || ps_re == aw_re - 1) &&
                           (ps_im == aw_im || ps_im == aw_im - 1));
  end
endmodule

// File: rtl/cg_fold_ctrl.sv
module cg_fold_ctrl
  import cg_fft_pkg::*;
#(
  parameter int P = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load,
  output logic             run,
  output logic             last_sub,
  output logic [1:0]       stage,
  output logic [SUB_W-1:0] sub
);
  localparam int SUBS  = HALF / P;
  localparam int SUB_W = (SUBS > 1) ? $clog2(SUBS) : 1;
  localparam int TOTAL = NSTG * SUBS;
  localparam int LAT_W = $clog2(TOTAL + 1) + 1;

  eng_state_e       state_q;
  logic [1:0]       stage_q;
  logic [SUB_W-1:0] sub_q;

  assign in_ready  = (state_q == EN_IDLE);
  assign out_valid = (state_q == EN_DONE);
  assign run       = (state_q == EN_RUN);
  assign load      = in_valid && in_ready;
  assign last_sub  = (sub_q == SUB_W'(SUBS - 1));
  assign stage     = stage_q;
  assign sub       = sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EN_IDLE;
      stage_q <= '0;
      sub_q   <= '0;
    end else begin
      case (state_q)
        EN_IDLE: if (in_valid) begin
          state_q <= EN_RUN;
          stage_q <= '0;
          sub_q   <= '0;
        end
        EN_RUN: begin
          if (last_sub) begin
            sub_q <= '0;
            if (stage_q == 2'(NSTG - 1)) state_q <= EN_DONE;
            else                         stage_q <= stage_q + 2'd1;
          end else begin
            sub_q <= sub_q + SUB_W'(1);
          end
        end
        EN_DONE: if (out_ready) state_q <= EN_IDLE;
        default: state_q <= EN_IDLE;
      endcase
    end
  end

  // Checker counter for the fold latency
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (load) lat_q <= '0;
    else if (run)  lat_q <= lat_q + LAT_W'(1);
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == LAT_W'(TOTAL));
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !in_ready);
  p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);
  p_sub_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sub_q) < SUBS);
endmodule

// File: rtl/cg_fft_engine.sv
module cg_fft_engine
  import cg_fft_pkg::*;
#(
  parameter int W = 16,
  parameter int P = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NPT*W-1:0]   in_re,
  input  logic [NPT*W-1:0]   in_im,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NPT*W-1:0]   out_re,
  output logic [NPT*W-1:0]   out_im
);
  localparam int SUBS  = HALF / P;
  localparam int SUB_W = (SUBS > 1) ? $clog2(SUBS) : 1;

  logic             load, run, last_sub;
  logic [1:0]       stage;
  logic [SUB_W-1:0] sub;

  cg_fold_ctrl #(.P(P)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load), .run(run),
    .last_sub(last_sub), .stage(stage), .sub(sub)
  );

  // cur: operands of the current pass; nxt: results collected during it
  logic signed [W-1:0] cur_re [NPT];
  logic signed [W-1:0] cur_im [NPT];
  logic signed [W-1:0] nxt_re [NPT];
  logic signed [W-1:0] nxt_im [NPT];
  logic signed [W-1:0] upd_re [NPT];
  logic signed [W-1:0] upd_im [NPT];

  logic [2:0]          bk    [P];
  logic signed [W-1:0] bx_re [P];
  logic signed [W-1:0] bx_im [P];
  logic signed [W-1:0] by_re [P];
  logic signed [W-1:0] by_im [P];

  for (genvar p = 0; p < P; p++) begin : g_bfly
    logic [2:0]             tix;
    logic signed [TW_W-1:0] tw_re, tw_im;
    assign bk[p] = 3'(int'(sub) * P + p);
    assign tix   = tw_index(stage, bk[p]);
    cg_twiddle_rom u_rom (.idx(tix), .w_re(tw_re), .w_im(tw_im));
    cg_butterfly #(.W(W)) u_bf (
      .a_re(cur_re[bk[p]]), .a_im(cur_im[bk[p]]),
      .b_re(cur_re[4'(bk[p]) + 4'd8]), .b_im(cur_im[4'(bk[p]) + 4'd8]),
      .w_re(tw_re), .w_im(tw_im),
      .x_re(bx_re[p]), .x_im(bx_im[p]), .y_re(by_re[p]), .y_im(by_im[p])
    );
  end

  // Perfect-shuffle write-back: butterfly k lands in lanes 2k and 2k+1
  always_comb begin
    for (int i = 0; i < NPT; i++) begin
      upd_re[i] = nxt_re[i];
      upd_im[i] = nxt_im[i];
    end
    for (int p = 0; p < P; p++) begin
      upd_re[{bk[p], 1'b0}] = bx_re[p];
      upd_im[{bk[p], 1'b0}] = bx_im[p];
      upd_re[{bk[p], 1'b1}] = by_re[p];
      upd_im[{bk[p], 1'b1}] = by_im[p];
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NPT; i++) begin
        cur_re[i] <= in_re[i*W +: W];
        cur_im[i] <= in_im[i*W +: W];
      end
    end else if (run) begin
      for (int i = 0; i < NPT; i++) begin
        if (last_sub) begin
          cur_re[i] <= upd_re[i];
          cur_im[i] <= upd_im[i];
        end else begin
          nxt_re[i] <= upd_re[i];
          nxt_im[i] <= upd_im[i];
        end
      end
    end
  end

  for (genvar i = 0; i < NPT; i++) begin : g_out
    assign out_re[i*W +: W] = cur_re[i];
    assign out_im[i*W +: W] = cur_im[i];
  end

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_re) && $stable(out_im));
  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run || out_valid) |-> !in_ready);
endmodule

// File: tb/cg_fft_engine_tb.sv
module cg_fft_engine_tb;
  localparam int  W     = 16;
  localparam int  P     = 2;
  localparam int  NPT   = 16;
  localparam int  TOTAL = 32 / P;
  localparam real TOL   = 6.0;
  localparam real PI    = 3.14159265358979;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             in_valid = 0, out_ready = 0;
  logic             in_ready, out_valid;
  logic [NPT*W-1:0] in_re = '0, in_im = '0;
  logic [NPT*W-1:0] out_re, out_im;

  int checks = 0, fails = 0, cyc = 0;
  int sx_re[NPT], sx_im[NPT];
  logic [NPT*W-1:0] snap_re, snap_im;

  always #5 clk = ~clk;

  cg_fft_engine #(.W(W), .P(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bitrev4(input int v);
    return ((v & 1) << 3) | ((v & 2) << 1) | ((v & 4) >> 1) | ((v & 8) >> 3);
  endfunction

  function automatic int lane(input logic [NPT*W-1:0] v, input int r);
    return int'($signed(v[r*W +: W]));
  endfunction

  task automatic push_stim();
    for (int n = 0; n < NPT; n++) begin
      in_re[n*W +: W] = W'(sx_re[n]);
      in_im[n*W +: W] = W'(sx_im[n]);
    end
  endtask

  // Drive one vector, check latency, result, hold and release
  task automatic run_vec(input bit junk, input int hold, input bit impulse);
    int  lat;
    real er, ei, th;
    @(negedge clk);
    push_stim();
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    if (junk) begin
      in_re = ~in_re;
      in_im = in_re ^ 256'h5a5a;
    end else begin
      in_valid = 0;
    end
    lat = 0;
    while (!out_valid && lat < 200) begin
      if (junk) chk(!in_ready, "R2", "in_ready while busy", in_ready, 0);
      @(negedge clk);
      lat++;
    end
    chk(lat == TOTAL, "R3", "latency", lat, TOTAL);
    for (int r = 0; r < NPT; r++) begin
      int f;
      f  = bitrev4(r);
      er = 0.0;
      ei = 0.0;
      for (int n = 0; n < NPT; n++) begin
        th = 2.0 * PI * real'(f * n) / 16.0;
        er += real'(sx_re[n]) * $cos(th) + real'(sx_im[n]) * $sin(th);
        ei += real'(sx_im[n]) * $cos(th) - real'(sx_re[n]) * $sin(th);
      end
      er /= 16.0;
      ei /= 16.0;
      chk(((real'(lane(out_re, r)) - er) <= TOL) && ((er - real'(lane(out_re, r))) <= TOL),
          junk ? "R4/R2" : "R4", $sformatf("lane %0d re", r), lane(out_re, r), longint'(er));
      chk(((real'(lane(out_im, r)) - ei) <= TOL) && ((ei - real'(lane(out_im, r))) <= TOL),
          junk ? "R4/R2" : "R4", $sformatf("lane %0d im", r), lane(out_im, r), longint'(ei));
      if (impulse) begin
        chk(lane(out_re, r) == (sx_re[0] >>> 4), "R7", $sformatf("lane %0d re exact", r),
            lane(out_re, r), sx_re[0] >>> 4);
        chk(lane(out_im, r) == 0, "R7/R8", $sformatf("lane %0d im exact", r),
            lane(out_im, r), 0);
      end
    end
    snap_re = out_re;
    snap_im = out_im;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R5", "valid held", out_valid, 1);
      chk(out_re == snap_re && out_im == snap_im, "R5", "data held", 0, 0);
    end
    in_valid  = 0;
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid == 1'b0, "R6", "valid after accept", out_valid, 0);
    chk(in_ready == 1'b1, "R6", "ready after accept", in_ready, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20417);
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R7: impulse in sample 0
    for (int n = 0; n < NPT; n++) begin sx_re[n] = 0; sx_im[n] = 0; end
    sx_re[0] = 4096;
    run_vec(0, 0, 1);
    sx_re[0] = -3000;
    run_vec(0, 2, 1);

    // Constant input: energy only in bin 0
    for (int n = 0; n < NPT; n++) begin sx_re[n] = 1000; sx_im[n] = -700; end
    run_vec(0, 0, 0);

    // Single complex tone in bin 3
    for (int n = 0; n < NPT; n++) begin
      sx_re[n] = int'(7000.0 * $cos(2.0 * PI * 3.0 * real'(n) / 16.0));
      sx_im[n] = int'(7000.0 * $sin(2.0 * PI * 3.0 * real'(n) / 16.0));
    end
    run_vec(1, 3, 0);

    // Constrained random vectors, full scale of +/-8191
    for (int t = 0; t < 10; t++) begin
      for (int n = 0; n < NPT; n++) begin
        sx_re[n] = int'($urandom_range(16382)) - 8191;
        sx_im[n] = int'($urandom_range(16382)) - 8191;
      end
      run_vec(t % 3 == 1, t % 4, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule